// File: doc/BRIEF.md
# Flash Sequencer Status Register

This block holds the 16-bit status word of a flash controller that runs its commands through an automatic hardware sequencer. It records whether a flash cycle is running. It latches three sticky event flags: cycle done, cycle error and access error. It reports the erase granularity of the flash region being addressed. It carries a configuration lock that stays set until the next reset.

Software reads the word on `reg_rdata` and writes it through `reg_wr` / `reg_wdata`. The surrounding controller supplies several strobes: a cycle-go request, a write-to-program-register strobe, the sequencer's completion strobe, a protection-block strobe and a protection-violation strobe. The block gates the cycle-go request. It passes the request to the sequencer as `cyc_start` only when the flash descriptor is valid, no cycle is running and no cycle error is pending. It also withholds program-register writes once the configuration is locked.

Top module: `flash_seq_status`

## Requirements
- R1: After reset, bits 15, 5, 2, 1 and 0 read 0, bits 12 to 6 read 0, and `cyc_start` and `prog_wr_grant` are 0.
- R2: Writing 1 to bit 15 sets the lock bit. Writing 0 does not clear it, and only reset clears it. While the lock bit is 1, `prog_wr_grant` is 0. While it is 0, `prog_wr_grant` equals `prog_wr_req`.
- R3: Bit 14 always shows `desc_valid`. Bit 13 always shows `ovr_strap` (1 = no override, 0 = override active). Bits 12 to 6 always read 0.
- R4: A cycle-go request that is accepted drives `cyc_start` high in that cycle and sets bit 5 (busy) at the next clock edge. Bit 5 stays 1 until `cyc_done` is seen while it is 1. Software writes never change bit 5.
- R5: A cycle-go request while `desc_valid` is 0 does not raise `cyc_start` or set bit 5. It sets bit 1 (cycle error) at the next clock edge.
- R6: A program-register write (`prog_wr_req`) or a cycle-go request while bit 5 is 1 sets bit 1 at the next clock edge, and bit 5 stays set.
- R7: A cycle-go request while bit 1 is 1 is ignored: `cyc_start` stays 0 and bit 5 stays 0.
- R8: `prot_block` sets bit 1. Writing 1 to bit 1 clears it, and writing 0 leaves it unchanged.
- R9: `acc_viol` sets bit 2 (access error). Writing 1 to bit 2 clears it, and writing 0 leaves it unchanged.
- R10: Bits 4:3 give the erase size code (00 = 256 B, 01 = 4 KB, 10 = 8 KB, 11 = 64 KB). The field shows `lo_size` when `flash_addr` < `part_base` and `hi_size` otherwise.
- R11: When a hardware set and a software write-1 clear reach bit 0, 1 or 2 in the same cycle, the bit ends up 1.
- R12: Bit 0 (cycle done) is set when `cyc_done` arrives while bit 5 is 1. Writing 1 to bit 0 clears it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Status register write strobe |
| reg_wdata | input | 16 | Status register write data |
| reg_rdata | output | 16 | Status register read value |
| go_req | input | 1 | Software cycle-go request |
| cyc_start | output | 1 | Accepted cycle start toward the sequencer |
| cyc_done | input | 1 | Sequencer cycle completion strobe |
| prog_wr_req | input | 1 | Software write to a protected program/cycle register |
| prog_wr_grant | output | 1 | Program-register write allowed |
| desc_valid | input | 1 | Flash descriptor signature valid |
| ovr_strap | input | 1 | Descriptor override strap (1 = no override) |
| prot_block | input | 1 | Programmed access blocked by protection |
| acc_viol | input | 1 | Protection-violating direct read |
| lo_size | input | 2 | Erase size code below the partition boundary |
| hi_size | input | 2 | Erase size code at or above the boundary |
| flash_addr | input | AW | Current flash address |
| part_base | input | AW | Partition boundary address |

## Verification
Every internal state bit drives a bit of `reg_rdata`, so a wrong busy, lock or sticky flag is visible at the read port one clock after the event that should have changed it. A wrong acceptance decision shows up in the same cycle as a wrong `cyc_start`. It also shows up one clock later as a busy bit or error bit with the wrong value. A mis-gated lock shows up combinationally on `prog_wr_grant`. An erase-size selection that goes the wrong way at the boundary shows up at once, because the field is combinational in the address.

// File: rtl/fss_pkg.sv
package fss_pkg;
    localparam int STAT_W     = 16;
    localparam int BIT_DONE   = 0;
    localparam int BIT_ERR    = 1;
    localparam int BIT_AEL    = 2;
    localparam int BIT_ESZ_LO = 3;
    localparam int BIT_BUSY   = 5;
    localparam int BIT_STRAP  = 13;
    localparam int BIT_DVALID = 14;
    localparam int BIT_LOCK   = 15;
    localparam int N_STICKY   = 3;

    typedef enum logic [1:0] {
        ESZ_256B = 2'b00,
        ESZ_4K   = 2'b01,
        ESZ_8K   = 2'b10,
        ESZ_64K  = 2'b11
    } erase_code_e;

    typedef struct packed {
        logic lock;
        logic busy;
    } ctl_t;
endpackage

// File: rtl/fss_w1c_bit.sv
module fss_w1c_bit (
    input  logic clk,
    input  logic rst_n,
    input  logic set_i,
    input  logic clr_i,
    output logic q_o
);
    logic flag_d, flag_q;

    always_comb begin
        flag_d = flag_q;
        if (clr_i) flag_d = 1'b0;
        if (set_i) flag_d = 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) flag_q <= 1'b0;
        else        flag_q <= flag_d;
    end

    assign q_o = flag_q;
endmodule

// File: rtl/fss_erase_sel.sv
module fss_erase_sel
    import fss_pkg::*;
#(
    parameter int AW = 24
) (
    input  logic [AW-1:0] addr_i,
    input  logic [AW-1:0] bound_i,
    input  logic [1:0]    lo_i,
    input  logic [1:0]    hi_i,
    output erase_code_e   code_o
);
    logic below;

    always_comb begin
        below  = (addr_i < bound_i);
        code_o = below ? erase_code_e'(lo_i) : erase_code_e'(hi_i);
    end
endmodule

// File: rtl/flash_seq_status.sv
module flash_seq_status
    import fss_pkg::*;
#(
    parameter int AW = 24
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_wr,
    input  logic [STAT_W-1:0] reg_wdata,
    output logic [STAT_W-1:0] reg_rdata,
    input  logic              go_req,
    output logic              cyc_start,
    input  logic              cyc_done,
    input  logic              prog_wr_req,
    output logic              prog_wr_grant,
    input  logic              desc_valid,
    input  logic              ovr_strap,
    input  logic              prot_block,
    input  logic              acc_viol,
    input  logic [1:0]        lo_size,
    input  logic [1:0]        hi_size,
    input  logic [AW-1:0]     flash_addr,
    input  logic [AW-1:0]     part_base
);
    localparam int RSV_LO = BIT_BUSY + 1;
    localparam int RSV_W  = BIT_STRAP - RSV_LO;

    ctl_t                ctl_d, ctl_q;
    logic [N_STICKY-1:0] st_set, st_clr, st_q;
    logic                go_ok, go_bad, err_evt, done_evt;
    erase_code_e         esize;
    logic                unused_wdata;

    assign unused_wdata = ^reg_wdata[BIT_LOCK-1:N_STICKY];

    always_comb begin
        ctl_d    = ctl_q;
        go_ok    = go_req && desc_valid && !ctl_q.busy && !st_q[BIT_ERR];
        go_bad   = go_req && (!desc_valid || ctl_q.busy);
        err_evt  = go_bad || prot_block || (prog_wr_req && ctl_q.busy);
        done_evt = ctl_q.busy && cyc_done;

        if (reg_wr && reg_wdata[BIT_LOCK]) ctl_d.lock = 1'b1;
        if (done_evt)                       ctl_d.busy = 1'b0;
        if (go_ok)                          ctl_d.busy = 1'b1;

        st_set           = '0;
        st_set[BIT_DONE] = done_evt;
        st_set[BIT_ERR]  = err_evt;
        st_set[BIT_AEL]  = acc_viol;
        st_clr           = reg_wr ? reg_wdata[N_STICKY-1:0] : '0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) ctl_q <= '0;
        else        ctl_q <= ctl_d;
    end

    for (genvar i = 0; i < N_STICKY; i++) begin : g_sticky
        fss_w1c_bit u_flag (
            .clk  (clk),
            .rst_n(rst_n),
            .set_i(st_set[i]),
            .clr_i(st_clr[i]),
            .q_o  (st_q[i])
        );
    end

    fss_erase_sel #(.AW(AW)) u_esel (
        .addr_i (flash_addr),
        .bound_i(part_base),
        .lo_i   (lo_size),
        .hi_i   (hi_size),
        .code_o (esize)
    );

    always_comb begin
        reg_rdata                         = '0;
        reg_rdata[BIT_LOCK]               = ctl_q.lock;
        reg_rdata[BIT_DVALID]             = desc_valid;
        reg_rdata[BIT_STRAP]              = ovr_strap;
        reg_rdata[RSV_LO +: RSV_W]        = '0;
        reg_rdata[BIT_BUSY]               = ctl_q.busy;
        reg_rdata[BIT_ESZ_LO +: 2]        = esize;
        reg_rdata[N_STICKY-1:0]           = st_q;
    end

    assign cyc_start     = go_ok;
    assign prog_wr_grant = prog_wr_req && !ctl_q.lock;
endmodule

// File: rtl/fss_checker.sv
module fss_checker (
    input logic clk,
    input logic rst_n,
    input logic go_req,
    input logic cyc_start,
    input logic cyc_done,
    input logic desc_valid,
    input logic prog_wr_req,
    input logic prog_wr_grant,
    input logic acc_viol,
    input logic lock_b,
    input logic busy_b,
    input logic ael_b,
    input logic err_b,
    input logic done_b
);
    p_lock_sticky_r2: assert property (@(posedge clk) disable iff (!rst_n)
        lock_b |=> lock_b);
    p_lock_blocks_r2: assert property (@(posedge clk) disable iff (!rst_n)
        lock_b |-> !prog_wr_grant);
    p_start_busy_r4: assert property (@(posedge clk) disable iff (!rst_n)
        cyc_start |=> busy_b);
    p_done_clears_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_b && cyc_done) |=> (!busy_b && done_b));
    p_nodesc_err_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (go_req && !desc_valid) |=> (err_b && !busy_b));
    p_busy_wr_err_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_b && prog_wr_req) |=> (err_b && busy_b));
    p_err_blocks_go_r7: assert property (@(posedge clk) disable iff (!rst_n)
        err_b |-> !cyc_start);
    p_viol_logs_r9: assert property (@(posedge clk) disable iff (!rst_n)
        acc_viol |=> ael_b);
endmodule

bind flash_seq_status fss_checker u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .go_req       (go_req),
    .cyc_start    (cyc_start),
    .cyc_done     (cyc_done),
    .desc_valid   (desc_valid),
    .prog_wr_req  (prog_wr_req),
    .prog_wr_grant(prog_wr_grant),
    .acc_viol     (acc_viol),
    .lock_b       (reg_rdata[15]),
    .busy_b       (reg_rdata[5]),
    .ael_b        (reg_rdata[2]),
    .err_b        (reg_rdata[1]),
    .done_b       (reg_rdata[0])
);

// File: tb/tb_flash_seq_status.sv
module tb_flash_seq_status;
    localparam int AW = 24;

    logic          clk = 1'b0;
    logic          rst_n;
    logic          reg_wr;
    logic [15:0]   reg_wdata;
    logic [15:0]   reg_rdata;
    logic          go_req, cyc_start, cyc_done;
    logic          prog_wr_req, prog_wr_grant;
    logic          desc_valid, ovr_strap, prot_block, acc_viol;
    logic [1:0]    lo_size, hi_size;
    logic [AW-1:0] flash_addr, part_base;

    int n_chk = 0;
    int n_bad = 0;

    always #5 clk = ~clk;

    flash_seq_status #(.AW(AW)) dut (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_wdata(reg_wdata),
        .reg_rdata(reg_rdata), .go_req(go_req), .cyc_start(cyc_start),
        .cyc_done(cyc_done), .prog_wr_req(prog_wr_req), .prog_wr_grant(prog_wr_grant),
        .desc_valid(desc_valid), .ovr_strap(ovr_strap), .prot_block(prot_block),
        .acc_viol(acc_viol), .lo_size(lo_size), .hi_size(hi_size),
        .flash_addr(flash_addr), .part_base(part_base)
    );

    task automatic check(input string tag, input logic [15:0] got, input logic [15:0] exp);
        n_chk++;
        if (got !== exp) begin
            n_bad++;
            $display("FAIL %s: got %h expected %h", tag, got, exp);
        end
    endtask

    task automatic step();
        @(negedge clk);
    endtask

    task automatic wr(input logic [15:0] d);
        reg_wr = 1'b1; reg_wdata = d;
        step();
        reg_wr = 1'b0; reg_wdata = '0;
    endtask

    task automatic t_reset();
        #1;
        check("R1 reset word", reg_rdata, 16'h6000);
        check("R1 reset strobes", {14'd0, cyc_start, prog_wr_grant}, 16'h0);
    endtask

    task automatic t_mirror();
        desc_valid = 1'b0; ovr_strap = 1'b0; #1;
        check("R3 mirrors low", reg_rdata, 16'h0000);
        desc_valid = 1'b1; #1;
        check("R3 dvalid only", reg_rdata, 16'h4000);
        ovr_strap = 1'b1; #1;
        check("R3 both high, reserved zero", reg_rdata & 16'h7FC0, 16'h6000);
        step();
    endtask

    task automatic t_erase();
        lo_size = 2'b01; hi_size = 2'b11; part_base = 24'h001000;
        flash_addr = 24'h000FFF; #1;
        check("R10 below boundary", {14'd0, reg_rdata[4:3]}, 16'd1);
        flash_addr = 24'h001000; #1;
        check("R10 at boundary", {14'd0, reg_rdata[4:3]}, 16'd3);
        hi_size = 2'b10; flash_addr = 24'hFFFFFF; #1;
        check("R10 top address", {14'd0, reg_rdata[4:3]}, 16'd2);
        lo_size = 2'b00; hi_size = 2'b00; flash_addr = '0; part_base = '0;
        step();
    endtask

    task automatic t_cycle();
        go_req = 1'b1; #1;
        check("R4 start pulse", {15'd0, cyc_start}, 16'd1);
        step(); go_req = 1'b0;
        check("R4 busy set", {15'd0, reg_rdata[5]}, 16'd1);
        wr(16'h0000);
        check("R4 busy not writable", {15'd0, reg_rdata[5]}, 16'd1);
        step();
        check("R4 busy holds", {15'd0, reg_rdata[5]}, 16'd1);
        cyc_done = 1'b1; step(); cyc_done = 1'b0;
        check("R4/R12 done clears busy sets done", reg_rdata[5:0], 16'h0001);
        wr(16'h0020);
        check("R4 write 1 to busy ignored", {15'd0, reg_rdata[5]}, 16'd0);
        wr(16'h0001);
        check("R12 done cleared by W1C", {15'd0, reg_rdata[0]}, 16'd0);
    endtask

    task automatic t_nodesc();
        desc_valid = 1'b0; go_req = 1'b1; #1;
        check("R5 no start without descriptor", {15'd0, cyc_start}, 16'd0);
        step(); go_req = 1'b0; desc_valid = 1'b1;
        check("R5 error set, not busy", reg_rdata[5:0], 16'h0002);
        wr(16'h0002);
        check("R8 error cleared", {15'd0, reg_rdata[1]}, 16'd0);
    endtask

    task automatic t_busy_err();
        go_req = 1'b1; step(); go_req = 1'b0;
        prog_wr_req = 1'b1; step(); prog_wr_req = 1'b0;
        check("R6 write during cycle", reg_rdata[5:0], 16'h0022);
        wr(16'h0002);
        go_req = 1'b1; #1;
        check("R6 go while busy no start", {15'd0, cyc_start}, 16'd0);
        step(); go_req = 1'b0;
        check("R6 go during cycle errors", reg_rdata[5:0], 16'h0022);
        wr(16'h0002);
        cyc_done = 1'b1; step(); cyc_done = 1'b0;
        wr(16'h0001);
        check("R6 cleanup", reg_rdata[5:0], 16'h0000);
    endtask

    task automatic t_err_block();
        prot_block = 1'b1; step(); prot_block = 1'b0;
        check("R8 protection block sets error", {15'd0, reg_rdata[1]}, 16'd1);
        go_req = 1'b1; #1;
        check("R7 go ignored under error", {15'd0, cyc_start}, 16'd0);
        step(); go_req = 1'b0;
        check("R7 busy stays clear", {15'd0, reg_rdata[5]}, 16'd0);
        wr(16'h0000);
        check("R8 write 0 no effect", {15'd0, reg_rdata[1]}, 16'd1);
        wr(16'h0002);
        check("R8 write 1 clears", {15'd0, reg_rdata[1]}, 16'd0);
    endtask

    task automatic t_ael();
        acc_viol = 1'b1; step(); acc_viol = 1'b0;
        check("R9 violation logged", reg_rdata[2:0], 16'h0004);
        wr(16'h0000);
        check("R9 write 0 no effect", {15'd0, reg_rdata[2]}, 16'd1);
        acc_viol = 1'b1; wr(16'h0004); acc_viol = 1'b0;
        check("R11 set beats clear", {15'd0, reg_rdata[2]}, 16'd1);
        wr(16'h0004);
        check("R9 write 1 clears", {15'd0, reg_rdata[2]}, 16'd0);
        prot_block = 1'b1; wr(16'h0002); prot_block = 1'b0;
        check("R11 error set beats clear", {15'd0, reg_rdata[1]}, 16'd1);
        wr(16'h0002);
    endtask

    task automatic t_lock();
        prog_wr_req = 1'b1; #1;
        check("R2 grant while unlocked", {15'd0, prog_wr_grant}, 16'd1);
        prog_wr_req = 1'b0;
        wr(16'h8000);
        check("R2 lock set", {15'd0, reg_rdata[15]}, 16'd1);
        prog_wr_req = 1'b1; #1;
        check("R2 grant withheld", {15'd0, prog_wr_grant}, 16'd0);
        prog_wr_req = 1'b0;
        wr(16'h0000);
        check("R2 lock not cleared by write", {15'd0, reg_rdata[15]}, 16'd1);
        rst_n = 1'b0; #1;
        check("R2 reset clears lock", {15'd0, reg_rdata[15]}, 16'd0);
        step(); rst_n = 1'b1; step();
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        rst_n = 1'b0; reg_wr = 1'b0; reg_wdata = '0;
        go_req = 1'b0; cyc_done = 1'b0; prog_wr_req = 1'b0;
        desc_valid = 1'b1; ovr_strap = 1'b1; prot_block = 1'b0; acc_viol = 1'b0;
        lo_size = 2'b00; hi_size = 2'b00; flash_addr = '0; part_base = '0;
        step(); step();
        t_reset();
        rst_n = 1'b1; step();
        t_reset();
        t_mirror();
        t_erase();
        t_cycle();
        t_nodesc();
        t_busy_err();
        t_err_block();
        t_ael();
        t_lock();
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule